// File: doc/BRIEF.md
# Converter Register-Access SPI Master

This block carries single-byte register writes and reads from a system-clock domain to external data converters and clock chips over SPI. A caller presents one request: a read/write flag, a 13-bit register address, a write byte, a slave index, a wire-mode choice and an optional routing byte. The block forms the serial instruction stream, shifts it out, and reports the end of the transfer with a one-cycle `done` pulse. On reads, the returned byte appears on `rdata` at the same time as `done`.

SCLK comes from a counter on the system clock, not from a second clock. One bit takes five system clocks: SCLK is low for three of them and high for two. The bus uses SPI mode 0. SCLK idles low, the master changes its output on falling SCLK, and it samples input on the system clock where SCLK rises. Each slave has its own active-low select line.

In 4-wire mode, read data arrives on `miso`. In 3-wire mode, read data arrives on the shared data line. That line is driven through an external bidirectional pad that the block steers with `sdio_out` and `sdio_oe`. The master releases the line for the eight data bits of a read so the slave can drive it.

Top module: `conv_spi_master`

## Requirements
- R1: A frame is shifted MSB first in this order: the read flag (1 = read, 0 = write), two byte-count bits always 0, the 13-bit address, then 8 data bits. The data bits are the write byte on a write and 0 on a read. Without a routing byte the frame is 24 bits long.
- R2: SCLK idles low. `mosi` changes only on a system clock where SCLK falls (or at the start of a transfer), so it is stable while SCLK is high.
- R3: When `req_pre_en` is 1, the 8-bit `req_pre_byte` is sent MSB first ahead of the 24-bit frame, for 32 bits in total.
- R4: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. `done` rises 5·N system clocks after that edge, where N is the frame length in bits. `busy` is 1 from the cycle after acceptance until the `done` cycle, and 0 in the `done` cycle.
- R5: Every SCLK period lasts five system clocks: two with SCLK high followed by three with SCLK low. A transfer holds SCLK high for exactly 2·N system clocks.
- R6: `cs_n[k]` is 0 for the whole transfer when `req_slave` = k and k < 3. All other select lines stay 1. An index of 3 selects no slave, but the transfer still runs.
- R7: On a read, 8 bits are sampled MSB first at the rising SCLK edges of the data phase. The source is `miso` in 4-wire mode (`req_three_wire` = 0) and `sdio_in` in 3-wire mode. The byte appears on `rdata` in the `done` cycle and is held until the next `done`.
- R8: `sdio_oe` is 1 during a 3-wire transfer except during the 8 data bits of a 3-wire read. It is 0 when idle and throughout 4-wire transfers. `sdio_out` always equals `mosi`.
- R9: `done` lasts exactly one cycle. A request presented while `busy` is 1 is ignored: it does not change the running frame, and no transfer follows from it.
- R10: A write transfer ends with `rdata` = 0, even when a previous read left a non-zero byte on `rdata`.
- R11: While reset is asserted, and after it is released, `busy`, `done`, `sclk`, `mosi` and `sdio_oe` are 0, `rdata` is 0, and all `cs_n` lines are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_three_wire | input | 1 | 1 = shared data line, 0 = separate MOSI/MISO |
| req_pre_en | input | 1 | Send routing byte ahead of the frame |
| req_pre_byte | input | 8 | Routing byte |
| req_addr | input | 13 | Register start address |
| req_wdata | input | 8 | Write byte |
| req_slave | input | 2 | Slave select index |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Read byte, 0 after a write |
| sclk | output | 1 | Serial clock (system clock / 5) |
| cs_n | output | 3 | Active-low select per slave |
| mosi | output | 1 | Master serial output |
| miso | input | 1 | Slave serial output, 4-wire mode |
| sdio_out | output | 1 | Value driven onto the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdio_in | input | 1 | Value read from the shared data line |

## Verification
The bench model of the slave drives the opposite bit onto the line that is not in use. A design that sampled the wrong input in 3-wire or 4-wire mode would therefore return the inverted byte. The bench records every bit at SCLK rises and compares it with its own frame. This catches a dropped byte-count bit, a missing or misplaced routing byte, or a 23- or 25-bit frame. It also counts SCLK-high cycles and the total latency, which an off-by-one in the 2-high/3-low divider would change. Further cases cover a write that follows a read, which must clear `rdata`, requests held during a busy transfer, which must neither corrupt the frame nor start a second one, and an out-of-range slave index, which must leave every select high.

// File: rtl/conv_spi_pkg.sv
package conv_spi_pkg;

  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int PRE_W   = 8;
  localparam int CNT_W   = 2;
  localparam int INST_W  = 1 + CNT_W + ADDR_W;
  localparam int CORE_W  = INST_W + DATA_W;
  localparam int FRAME_W = PRE_W + CORE_W;
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} xfer_state_t;

  // Left-aligned frame: routing byte (optional), flag, count, address, data.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              rd,
    input logic              pre_en,
    input logic [PRE_W-1:0]  pre,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata
  );
    logic [CORE_W-1:0] core;
    core = {rd, {CNT_W{1'b0}}, addr, (rd ? {DATA_W{1'b0}} : wdata)};
    if (pre_en) return {pre, core};
    return {core, {PRE_W{1'b0}}};
  endfunction

  function automatic logic [BITS_W-1:0] frame_bits(input logic pre_en);
    return pre_en ? BITS_W'(FRAME_W) : BITS_W'(CORE_W);
  endfunction

endpackage

// File: rtl/conv_spi_clkdiv.sv
module conv_spi_clkdiv #(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic evt_rise,
  output logic evt_fall
);
  localparam int PERIOD = LOW_CYC + HIGH_CYC;
  localparam int CW     = $clog2(PERIOD);

  logic [CW-1:0] cnt;

  assign evt_rise = run && (cnt == CW'(LOW_CYC - 1));
  assign evt_fall = run && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= evt_fall ? '0 : cnt + 1'b1;
      if (evt_rise)      sclk <= 1'b1;
      else if (evt_fall) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_spi_shifter.sv
module conv_spi_shifter
  import conv_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [BITS_W-1:0]  nbits_in,
  input  logic               shift,
  input  logic               sample,
  input  logic               sample_bit,
  output logic               ser_out,
  output logic [BITS_W-1:0]  bits_left,
  output logic               data_phase,
  output logic [DATA_W-1:0]  rx_byte
);
  logic [FRAME_W-1:0] shreg;

  assign ser_out    = shreg[FRAME_W-1];
  assign data_phase = (bits_left != '0) && (bits_left <= BITS_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
      rx_byte   <= '0;
    end else if (load) begin
      shreg     <= frame_in;
      bits_left <= nbits_in;
      rx_byte   <= '0;
    end else begin
      if (shift) begin
        shreg     <= {shreg[FRAME_W-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
      end
      if (sample && data_phase) rx_byte <= {rx_byte[DATA_W-2:0], sample_bit};
    end
  end
endmodule

// File: rtl/conv_spi_csdec.sv
module conv_spi_csdec #(
  parameter int NS = 3,
  parameter int IW = 2
) (
  input  logic [IW-1:0] sel,
  input  logic          active,
  output logic [NS-1:0] cs_n
);
  for (genvar i = 0; i < NS; i++) begin : g_cs
    assign cs_n[i] = !(active && (sel == IW'(i)));
  end
endmodule

// File: rtl/conv_spi_master.sv
module conv_spi_master
  import conv_spi_pkg::*;
#(
  parameter int NUM_SLV   = 3,
  parameter int SCLK_LOW  = 3,
  parameter int SCLK_HIGH = 2,
  localparam int SEL_W    = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic               req_three_wire,
  input  logic               req_pre_en,
  input  logic [PRE_W-1:0]   req_pre_byte,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [SEL_W-1:0]   req_slave,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic               sclk,
  output logic [NUM_SLV-1:0] cs_n,
  output logic               mosi,
  input  logic               miso,
  output logic               sdio_out,
  output logic               sdio_oe,
  input  logic               sdio_in
);
  xfer_state_t state;
  logic             xfer_read, xfer_3w;
  logic [SEL_W-1:0] xfer_sel;

  // Named internal events, also used by the checker.
  logic              accept, finish, evt_rise, evt_fall;
  logic              ser_out, data_phase, sample_bit;
  logic [BITS_W-1:0] bits_left;
  logic [DATA_W-1:0] rx_byte;

  assign busy       = (state == ST_SHIFT);
  assign accept     = req_valid && !busy;
  assign finish     = busy && evt_fall && (bits_left == BITS_W'(1));
  assign sample_bit = xfer_3w ? sdio_in : miso;

  conv_spi_clkdiv #(.LOW_CYC(SCLK_LOW), .HIGH_CYC(SCLK_HIGH)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .sclk(sclk), .evt_rise(evt_rise), .evt_fall(evt_fall)
  );

  conv_spi_shifter u_shf (
    .clk(clk), .rst_n(rst_n),
    .load(accept),
    .frame_in(build_frame(req_read, req_pre_en, req_pre_byte, req_addr, req_wdata)),
    .nbits_in(frame_bits(req_pre_en)),
    .shift(busy && evt_fall),
    .sample(busy && evt_rise && xfer_read),
    .sample_bit(sample_bit),
    .ser_out(ser_out), .bits_left(bits_left),
    .data_phase(data_phase), .rx_byte(rx_byte)
  );

  conv_spi_csdec #(.NS(NUM_SLV), .IW(SEL_W)) u_cs (
    .sel(xfer_sel), .active(busy), .cs_n(cs_n)
  );

  assign mosi     = busy && ser_out;
  assign sdio_out = mosi;
  assign sdio_oe  = busy && xfer_3w && !(xfer_read && data_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      xfer_read <= 1'b0;
      xfer_3w   <= 1'b0;
      xfer_sel  <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        state     <= ST_SHIFT;
        xfer_read <= req_read;
        xfer_3w   <= req_three_wire;
        xfer_sel  <= req_slave;
      end else if (finish) begin
        state <= ST_IDLE;
        rdata <= xfer_read ? rx_byte : '0;
      end
    end
  end
endmodule

// File: rtl/conv_spi_chk.sv
module conv_spi_chk #(
  parameter int NS = 3,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sclk,
  input logic [NS-1:0] cs_n,
  input logic          mosi,
  input logic          sdio_oe,
  input logic          sdio_out,
  input logic [7:0]    rdata,
  input logic          req_valid,
  input logic          xfer_read,
  input logic [IW-1:0] xfer_sel,
  input logic          data_phase
);
  // R5
  sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk ##1 !sclk);
  // R5
  sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && busy) |=> !sclk ##1 !sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R6
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));
  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdio_oe);
  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_read && data_phase) |-> !sdio_oe);
  // R8
  sdio_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_out == mosi);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(xfer_sel) && $stable(xfer_read));
  // R10
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !xfer_read) |-> (rdata == 8'h00));
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind conv_spi_master conv_spi_chk #(.NS(NUM_SLV), .IW(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk),
  .cs_n(cs_n), .mosi(mosi), .sdio_oe(sdio_oe), .sdio_out(sdio_out),
  .rdata(rdata), .req_valid(req_valid), .xfer_read(xfer_read),
  .xfer_sel(xfer_sel), .data_phase(data_phase)
);

// File: tb/conv_spi_master_tb.sv
module conv_spi_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_read = 0, req_three_wire = 0, req_pre_en = 0;
  logic [7:0] req_pre_byte = 0, req_wdata = 0;
  logic [12:0] req_addr = 0;
  logic [1:0] req_slave = 0;
  logic busy, done, sclk, mosi, miso, sdio_out, sdio_oe, sdio_in;
  logic [7:0] rdata;
  logic [2:0] cs_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_three_wire(req_three_wire), .req_pre_en(req_pre_en),
    .req_pre_byte(req_pre_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_slave(req_slave), .busy(busy), .done(done), .rdata(rdata),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdio_in(sdio_in)
  );

  // Slave model: answers with slv_byte during the last 8 bits; the unused line gets the inverse.
  int rise_cnt = 0, oe_low_rises = 0, mirror_bad = 0, exp_len = 24;
  logic [31:0] got = 0;
  logic [7:0] slv_byte = 0;
  logic slv_3w = 0, sbit;

  always_comb begin
    sbit = 1'b0;
    if (rise_cnt >= exp_len - 8 && rise_cnt < exp_len)
      sbit = slv_byte[7 - (rise_cnt - (exp_len - 8))];
  end
  assign miso    = slv_3w ? ~sbit : sbit;
  assign sdio_in = slv_3w ? sbit : ~sbit;

  always @(posedge sclk) begin
    got      <= {got[30:0], mosi};
    rise_cnt <= rise_cnt + 1;
    if (!sdio_oe) oe_low_rises <= oe_low_rises + 1;
    if (sdio_out != mosi) mirror_bad <= mirror_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {read, three_wire, pre_en, slave[1:0], pre[7:0], addr[12:0], wdata[7:0], slave_byte[7:0]}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 13'h00A5, 8'h3C, 8'h00},
    {1'b1, 1'b0, 1'b0, 2'd1, 8'h00, 13'h1FFF, 8'h00, 8'hA5},
    {1'b0, 1'b1, 1'b0, 2'd2, 8'h00, 13'h1000, 8'hFF, 8'h00},
    {1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 13'h0001, 8'h00, 8'h5A},
    {1'b0, 1'b0, 1'b1, 2'd1, 8'h81, 13'h0123, 8'h01, 8'h00},
    {1'b1, 1'b0, 1'b1, 2'd2, 8'h7E, 13'h0ABC, 8'h00, 8'hC3},
    {1'b1, 1'b1, 1'b1, 2'd1, 8'hFF, 13'h0000, 8'h00, 8'h80},
    {1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 13'h1555, 8'h96, 8'h00}
  };

  task automatic run_xfer(input logic [41:0] v, input bit poke_busy);
    logic rd, tw, pe; logic [1:0] sl; logic [7:0] pb, wd, rb; logic [12:0] ad;
    logic [31:0] exp_frame, mask; logic [2:0] exp_cs;
    int cyc, hi, exp_oe_low;
    {rd, tw, pe, sl, pb, ad, wd, rb} = v;
    exp_len   = pe ? 32 : 24;
    exp_frame = pe ? {pb, rd, 2'b00, ad, (rd ? 8'h00 : wd)}
                   : {8'h00, rd, 2'b00, ad, (rd ? 8'h00 : wd)};
    mask      = pe ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
    exp_cs    = (sl < 2'd3) ? ~(3'b001 << sl) : 3'b111;
    exp_oe_low = tw ? (rd ? 8 : 0) : exp_len;
    @(negedge clk);
    rise_cnt = 0; oe_low_rises = 0; mirror_bad = 0; got = 0;
    slv_byte = rb; slv_3w = tw;
    req_valid = 1; req_read = rd; req_three_wire = tw; req_pre_en = pe;
    req_pre_byte = pb; req_addr = ad; req_wdata = wd; req_slave = sl;
    @(negedge clk);
    req_valid = 0;
    cyc = 1; hi = 0;
    chk(busy === 1'b1, "R4", "busy after accept", busy, 1);
    chk(cs_n === exp_cs, "R6", "select lines", cs_n, exp_cs);
    while (!done && cyc < 400) begin
      if (sclk) hi++;
      if (poke_busy && cyc == 10) begin
        req_valid = 1; req_read = ~rd; req_pre_en = ~pe; req_addr = ~ad;
        req_wdata = ~wd; req_slave = sl + 2'd1; req_three_wire = ~tw;
      end
      if (poke_busy && cyc == 14) req_valid = 0;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 5 * exp_len + 1, "R4", "cycles to done", cyc, 5 * exp_len + 1);
    chk(busy === 1'b0, "R4", "busy in done cycle", busy, 0);
    chk(hi == 2 * exp_len, "R5", "sclk high cycles", hi, 2 * exp_len);
    chk(rise_cnt == exp_len, pe ? "R3" : "R1", "bit count", rise_cnt, exp_len);
    chk((got & mask) == exp_frame, pe ? "R3" : "R1", "frame", got & mask, exp_frame);
    chk(rdata === (rd ? rb : 8'h00), rd ? "R7" : "R10", "rdata", rdata, rd ? rb : 8'h00);
    chk(oe_low_rises == exp_oe_low, "R8", "oe low at rises", oe_low_rises, exp_oe_low);
    chk(mirror_bad == 0, "R8", "sdio_out mirror", mirror_bad, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done width", done, 0);
    chk(rdata === (rd ? rb : 8'h00), "R7", "rdata held", rdata, rd ? rb : 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk({busy, done, sclk, mosi, sdio_oe} === 5'b0, "R11", "ctrl in reset",
        {busy, done, sclk, mosi, sdio_oe}, 0);
    chk(cs_n === 3'b111, "R11", "cs_n in reset", cs_n, 3'b111);
    rst_n = 1;
    @(negedge clk);
    chk(rdata === 8'h00 && busy === 1'b0, "R11", "after release", {busy, rdata}, 0);

    for (int i = 0; i < NV; i++) run_xfer(VEC[i], 1'b0);

    // R9 requests while busy are ignored
    run_xfer({1'b1, 1'b0, 1'b0, 2'd2, 8'h00, 13'h0F0F, 8'h00, 8'h3E}, 1'b1);
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        if (busy || cs_n !== 3'b111) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R9", "no transfer after busy request", extra, 0);
    end

    // R10 write directly after a read
    run_xfer({1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 13'h0042, 8'h00, 8'hFF}, 1'b0);
    run_xfer({1'b0, 1'b1, 1'b1, 2'd0, 8'h11, 13'h0042, 8'h77, 8'hFF}, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule